// File: doc/BRIEF.md
# Dual-Plane Palette Index Generator

This block sits between the video fetch and the palette lookup of a bitmap display. Each character slot delivers two bytes together over a 16-bit video data path, one byte per bitplane, read from two RAM pages. The block turns the two bytes into a stream of palette indices, one per high-resolution pixel clock.

Each plane has its own pixel format, so the two planes can use different formats at the same time:
- **Wide format:** four bits per wide pixel.
- **Medium format:** two bits per pixel.
- **Narrow format:** one bit per high-resolution pixel.
- **Off:** the plane contributes nothing.

The bits drawn from the two planes are placed next to each other to form one index. Some useful mixes:
- A medium-format plane over a wide-format plane gives 64 colours. Two index bits change every pixel and four change every pixel pair.
- A narrow-format plane over a medium-format plane gives 8 colours at full horizontal resolution, with colour clash per pixel pair.
- A narrow-format plane over a wide-format plane gives 32 colours.

The fetch logic drives the load strobe once per byte, in step with the pixel clock enable. The palette RAM is addressed directly from the index output.

Top module: `dual_plane_index_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, the index output is 0 and both planes are latched in wide format (code 0).
- R2: A clock edge where both the pixel enable and the load strobe are high captures both plane bytes and both format codes. From that edge on, the index shows pixel 0 of the new bytes.
- R3: Format code 2 (narrow) yields one bit per pixel. The bits are taken from bit 7 down to bit 0, and a new bit appears after every enabled clock.
- R4: Format code 1 (medium) yields pixel n (n = 0..3) as the pair {bit 7−n, bit 3−n}, with the first-named bit more significant. A new pixel appears after every second enabled clock.
- R5: Format code 0 (wide) yields two pixels: {bit 7, bit 5, bit 3, bit 1} followed by {bit 6, bit 4, bit 2, bit 0}, with the first-named bit most significant. Each pixel is held for four enabled clocks.
- R6: The index holds plane 0's bits in its lowest w0 bits and plane 1's bits directly above them. All higher bits are zero. The width w is 4, 2 or 1 for codes 0, 1 and 2.
- R7: Format code 3 (off) gives its plane a width of zero. The other plane's bits then start at bit 0.
- R8: A format code that changes between loads has no effect on the output until the next load.
- R9: On a clock edge with the pixel enable low, the index does not change, whatever the load strobe, bytes and format codes do.
- R10: A load that arrives before the eight pixels of the current bytes are used up discards the rest. Output restarts at pixel 0 of the new bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pixEn | input | 1 | High-resolution pixel clock enable |
| loadStb | input | 1 | Load both plane bytes; acted on only with pixEn |
| plane0Byte | input | 8 | Byte of plane 0 (low RAM page) |
| plane1Byte | input | 8 | Byte of plane 1 (high RAM page) |
| plane0Mode | input | 2 | Format code of plane 0 (0 wide, 1 medium, 2 narrow, 3 off) |
| plane1Mode | input | 2 | Format code of plane 1 |
| pixIndex | output | 8 | Combined palette index |

## Verification
The index is decoded directly from the shift registers and the latched format codes. An error in any of these state elements reaches the output in the same cycle it occurs.

Different faults show up in different ways:
- A shifter that advances at the wrong rate corrupts the second pixel of the narrow format within one enabled clock. In the other formats it shows by the end of the first pixel pair.
- A format code latched at the wrong time changes the index width. This moves plane 1's bits to other index positions on the very next pixel.
- A phase counter that is not cleared on a load only shows once the medium or wide pixel boundary falls in the wrong place. This takes at most four enabled clocks after the load.

// File: rtl/dpig_pkg.sv
package dpig_pkg;

  localparam int NUM_PLANES = 2;

  typedef enum logic [1:0] {
    FMT_WIDE   = 2'd0,
    FMT_MEDIUM = 2'd1,
    FMT_NARROW = 2'd2,
    FMT_OFF    = 2'd3
  } pixFmt_t;

  // Strobes from control to datapath, one set per clock.
  typedef struct packed {
    logic                  load;
    logic [NUM_PLANES-1:0] adv;
  } stepStb_t;

  // Number of index bits a plane contributes in a given format.
  function automatic logic [2:0] fmtWidth(input pixFmt_t fmt);
    case (fmt)
      FMT_WIDE:   return 3'd4;
      FMT_MEDIUM: return 3'd2;
      FMT_NARROW: return 3'd1;
      default:    return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dpig_ctrl.sv
module dpig_ctrl
  import dpig_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pixEn,
  input  logic                       loadStb,
  input  pixFmt_t [NUM_PLANES-1:0]   fmtIn,
  output pixFmt_t [NUM_PLANES-1:0]   fmtCur,
  output stepStb_t                   stb
);

  localparam int PHASE_W = $clog2(BYTE_W);

  logic [PHASE_W-1:0] phase;
  logic               doLoad;
  logic               doStep;

  assign doLoad = pixEn & loadStb;
  assign doStep = pixEn & ~loadStb;

  // Phase counts enabled clocks since the last load.
  always_ff @(posedge clk) begin
    if (!rst_n)      phase <= '0;
    else if (doLoad) phase <= '0;
    else if (doStep) phase <= phase + 1'b1;
  end

  // Format codes are latched only at a load, so a pixel is never torn.
  always_ff @(posedge clk) begin
    if (!rst_n)      fmtCur <= {NUM_PLANES{FMT_WIDE}};
    else if (doLoad) fmtCur <= fmtIn;
  end

  assign stb.load = doLoad;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_adv
    logic pixDone;
    always_comb begin
      case (fmtCur[p])
        FMT_NARROW: pixDone = 1'b1;
        FMT_MEDIUM: pixDone = phase[0];
        FMT_WIDE:   pixDone = &phase[1:0];
        default:    pixDone = 1'b0;
      endcase
    end
    assign stb.adv[p] = doStep & pixDone;
  end

endmodule

// File: rtl/dpig_datapath.sv
module dpig_datapath
  import dpig_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  stepStb_t                            stb,
  input  pixFmt_t [NUM_PLANES-1:0]            fmtCur,
  input  logic [NUM_PLANES-1:0][BYTE_W-1:0]   planeByte,
  output logic [IDX_W-1:0]                    pixIndex
);

  localparam int HALF = BYTE_W / 2;

  logic [NUM_PLANES-1:0][3:0] planeBits;
  logic [NUM_PLANES-1:0][2:0] planeWid;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    logic [BYTE_W-1:0] shReg;

    always_ff @(posedge clk) begin
      if (!rst_n)          shReg <= '0;
      else if (stb.load)   shReg <= planeByte[p];
      else if (stb.adv[p]) shReg <= {shReg[BYTE_W-2:0], 1'b0};
    end

    // Interleaved unpacking: the current pixel always sits at the top taps.
    always_comb begin
      case (fmtCur[p])
        FMT_NARROW: planeBits[p] = {3'b000, shReg[BYTE_W-1]};
        FMT_MEDIUM: planeBits[p] = {2'b00, shReg[BYTE_W-1], shReg[HALF-1]};
        FMT_WIDE:   planeBits[p] = {shReg[BYTE_W-1], shReg[BYTE_W-3],
                                    shReg[BYTE_W-5], shReg[BYTE_W-7]};
        default:    planeBits[p] = 4'b0000;
      endcase
    end

    assign planeWid[p] = fmtWidth(fmtCur[p]);
  end

  // Pack planes upward from bit 0, each at the running width offset.
  always_comb begin
    logic [IDX_W-1:0] acc;
    logic [4:0]       off;
    acc = '0;
    off = '0;
    for (int p = 0; p < NUM_PLANES; p++) begin
      acc = acc | (IDX_W'(planeBits[p]) << off);
      off = off + 5'(planeWid[p]);
    end
    pixIndex = acc;
  end

endmodule

// File: rtl/dual_plane_index_gen.sv
module dual_plane_index_gen
  import dpig_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pixEn,
  input  logic              loadStb,
  input  logic [BYTE_W-1:0] plane0Byte,
  input  logic [BYTE_W-1:0] plane1Byte,
  input  logic [1:0]        plane0Mode,
  input  logic [1:0]        plane1Mode,
  output logic [IDX_W-1:0]  pixIndex
);

  stepStb_t                          stepStb;
  pixFmt_t [NUM_PLANES-1:0]          fmtIn;
  pixFmt_t [NUM_PLANES-1:0]          fmtCur;
  logic [NUM_PLANES-1:0][BYTE_W-1:0] planeByte;

  assign fmtIn[0]     = pixFmt_t'(plane0Mode);
  assign fmtIn[1]     = pixFmt_t'(plane1Mode);
  assign planeByte[0] = plane0Byte;
  assign planeByte[1] = plane1Byte;

  dpig_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .pixEn   (pixEn),
    .loadStb (loadStb),
    .fmtIn   (fmtIn),
    .fmtCur  (fmtCur),
    .stb     (stepStb)
  );

  dpig_datapath #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stepStb),
    .fmtCur    (fmtCur),
    .planeByte (planeByte),
    .pixIndex  (pixIndex)
  );

endmodule

// File: rtl/dpig_checker.sv
module dpig_checker
  import dpig_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pixEn,
  input logic              loadStb,
  input logic [BYTE_W-1:0] plane0Byte,
  input logic [BYTE_W-1:0] plane1Byte,
  input logic [1:0]        plane0Mode,
  input logic [1:0]        plane1Mode,
  input logic [IDX_W-1:0]  pixIndex,
  input stepStb_t          stepStb
);

  // R3
  narrow_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pixEn && loadStb && plane0Mode == 2'd2 && plane1Mode == 2'd2)
    |=> pixIndex == IDX_W'({$past(plane1Byte[BYTE_W-1]), $past(plane0Byte[BYTE_W-1])}));

  // R5
  wide_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pixEn && loadStb && plane0Mode == 2'd0 && plane1Mode == 2'd0)
    |=> pixIndex == IDX_W'($past({plane1Byte[7], plane1Byte[5], plane1Byte[3], plane1Byte[1],
                                  plane0Byte[7], plane0Byte[5], plane0Byte[3], plane0Byte[1]})));

  // R7
  off_planes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pixEn && loadStb && plane0Mode == 2'd3 && plane1Mode == 2'd3) |=> pixIndex == '0);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pixEn |=> $stable(pixIndex));

  // R9
  adv_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stepStb.adv != '0) |-> (pixEn && !stepStb.load));

endmodule

bind dual_plane_index_gen dpig_checker #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pixEn      (pixEn),
  .loadStb    (loadStb),
  .plane0Byte (plane0Byte),
  .plane1Byte (plane1Byte),
  .plane0Mode (plane0Mode),
  .plane1Mode (plane1Mode),
  .pixIndex   (pixIndex),
  .stepStb    (stepStb)
);

// File: tb/dual_plane_index_gen_bench.sv
`timescale 1ns/1ps
module dual_plane_index_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pixEn = 1'b0;
  logic       loadStb = 1'b0;
  logic [7:0] plane0Byte = '0;
  logic [7:0] plane1Byte = '0;
  logic [1:0] plane0Mode = '0;
  logic [1:0] plane1Mode = '0;
  logic [7:0] pixIndex;

  int vectors = 0;
  int errors = 0;

  // Bench model state
  logic [7:0] mb0 = '0, mb1 = '0;
  logic [1:0] mm0 = '0, mm1 = '0;
  int         k = 0;

  always #2.5 clk = ~clk;

  dual_plane_index_gen u_dual_plane_index_gen (
    .clk(clk), .rst_n(rst_n), .pixEn(pixEn), .loadStb(loadStb),
    .plane0Byte(plane0Byte), .plane1Byte(plane1Byte),
    .plane0Mode(plane0Mode), .plane1Mode(plane1Mode),
    .pixIndex(pixIndex)
  );

  function automatic logic [3:0] pixBits(input logic [1:0] m, input logic [7:0] b, input int kk);
    int n;
    case (m)
      2'd2: return {3'b000, b[7-kk]};
      2'd1: begin n = kk / 2; return {2'b00, b[7-n], b[3-n]}; end
      2'd0: return (kk < 4) ? {b[7], b[5], b[3], b[1]} : {b[6], b[4], b[2], b[0]};
      default: return 4'b0000;
    endcase
  endfunction

  function automatic int bitsOf(input logic [1:0] m);
    case (m)
      2'd0: return 4;
      2'd1: return 2;
      2'd2: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] expIdx();
    logic [15:0] v;
    v = 16'(pixBits(mm0, mb0, k)) | (16'(pixBits(mm1, mb1, k)) << bitsOf(mm0));
    return v[7:0];
  endfunction

  task automatic check(input string req);
    logic [7:0] e;
    e = expIdx();
    vectors++;
    if (pixIndex !== e) begin
      errors++;
      $display("FAIL %s: pixIndex=%02h expected=%02h (m0=%0d m1=%0d k=%0d)",
               req, pixIndex, e, mm0, mm1, k);
    end
  endtask

  task automatic tick(input logic pe, input logic ls, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [1:0] m0, input logic [1:0] m1);
    pixEn = pe; loadStb = ls; plane0Byte = b0; plane1Byte = b1;
    plane0Mode = m0; plane1Mode = m1;
    @(posedge clk);
    if (pe && ls) begin
      mb0 = b0; mb1 = b1; mm0 = m0; mm1 = m1; k = 0;
    end else if (pe) begin
      k++;
    end
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C61));
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    tick(1'b1, 1'b0, 8'hFF, 8'hFF, 2'd2, 2'd2);
    check("R1 after reset, no load");

    // Narrow over narrow: bit order and rate
    tick(1'b1, 1'b1, 8'hA5, 8'h3C, 2'd2, 2'd2);
    check("R2 load");
    for (int i = 1; i < 8; i++) begin
      tick(1'b1, 1'b0, 8'h00, 8'h00, 2'd2, 2'd2);
      check("R3 narrow sequence");
    end

    // Medium over wide: 64-colour mix
    tick(1'b1, 1'b1, 8'h96, 8'hC3, 2'd0, 2'd1);
    check("R4/R5/R6 load medium over wide");
    for (int i = 1; i < 8; i++) begin
      tick(1'b1, 1'b0, 8'h00, 8'h00, 2'd0, 2'd1);
      check("R4/R5/R6 medium over wide");
    end

    // Narrow over medium with codes changed mid-byte
    tick(1'b1, 1'b1, 8'h5A, 8'hF0, 2'd1, 2'd2);
    check("R6 narrow over medium");
    for (int i = 1; i < 5; i++) begin
      tick(1'b1, 1'b0, 8'h00, 8'h00, 2'd0, 2'd3);
      check("R8 codes changed without load");
    end

    // Strobe without enable is ignored
    tick(1'b0, 1'b1, 8'hFF, 8'h00, 2'd2, 2'd0);
    check("R9 load without enable ignored");
    tick(1'b0, 1'b0, 8'h11, 8'h22, 2'd3, 2'd3);
    check("R9 idle hold");

    // Early reload after 4 pixels
    tick(1'b1, 1'b1, 8'h81, 8'h7E, 2'd0, 2'd2);
    check("R10 early reload");
    tick(1'b1, 1'b0, 8'h00, 8'h00, 2'd0, 2'd2);
    check("R10 after early reload");

    // Plane 0 off: plane 1 starts at bit 0
    tick(1'b1, 1'b1, 8'hFF, 8'hB4, 2'd3, 2'd0);
    check("R7 plane0 off");
    tick(1'b1, 1'b1, 8'hE7, 8'hFF, 2'd1, 2'd3);
    check("R7 plane1 off");
    tick(1'b1, 1'b1, 8'hFF, 8'hFF, 2'd3, 2'd3);
    check("R7 both off");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic pe, ls;
      pe = ($urandom % 4) != 0;
      ls = (k == 7) || (($urandom % 12) == 0);
      tick(pe, ls, 8'($urandom), 8'($urandom), 2'($urandom), 2'($urandom));
      check("R3/R4/R5/R6/R8/R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule